// File: doc/BRIEF.md
# I2C Control Port for a Current-Sink DAC

This block is the serial control front end of a 10-bit current-output DAC. It acts as a target on a two-wire I2C bus. It runs from a fast system clock and samples the SCL and SDA pins as ordinary inputs. Each line passes through a synchronizer and a spike filter. The block then looks for bus conditions, matches its device address, acknowledges bytes, and assembles a 16-bit control word.

A write moves a complete word into a held input register. In the same cycle, the word's DAC code and software power-down bit move into the output registers. A read returns the held word, and the input register empties itself once both bytes have been sent. A separate active-low shutdown pin forces the power-down output at any time, without waiting for the clock. The only drive onto the bus is an enable that pulls SDA low.

Top module: `dac_i2c_ctrl`

## Requirements
- R1: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. A start that arrives with no stop before it (a repeated start) begins a new address phase.
- R2: The first byte after a start carries the 7-bit address, MSB first, followed by the R/W bit (0 = write, 1 = read). Any address from 0x0C to 0x0F is acknowledged by pulling SDA low during the ninth clock. Any other address gets no acknowledge, and the bus is ignored until the next start or stop.
- R3: A write carries a high byte and then a low byte, each MSB first. Both data bytes are acknowledged. A third data byte in the same write is not acknowledged.
- R4: The code and power-down outputs, and the held input register, change only when the sixteenth data bit has been received. A stop after a single data byte changes none of them.
- R5: In the 16-bit word, bit 15 is the software power-down and bits 13:4 are the DAC code (bit 13 = code MSB). Bits 14 and 3:0 do not affect any output.
- R6: A read returns the held word with the high byte first, each byte MSB first. The target releases SDA during each acknowledge slot.
- R7: After the second byte of a read has been sent, the held word becomes zero, so the next read returns 0x00, 0x00. The DAC code output is unchanged by this.
- R8: After reset, the DAC code is 0, the software power-down is 0, the held word is 0 and SDA is released.
- R9: While the shutdown pin is low, the power-down output is 1 regardless of any register. The path from the pin is combinational.
- R10: A pulse on SCL or SDA shorter than FILT_CYCLES clocks (13 clocks = 52 ns at 250 MHz) is never seen by the bus logic.
- R11: If the master answers a read byte with a NACK, the target stops driving SDA and stays idle until the next start.
- R12: SDA is driven only through a pull-low enable. The enable is 0 whenever the target is idle or ignoring the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Raw SCL pin level |
| sda_i | input | 1 | Raw SDA line level (the wired-AND of all drivers) |
| shdn_n_i | input | 1 | Asynchronous active-low shutdown |
| sda_pull_o | output | 1 | 1 = pull SDA low |
| dac_code_o | output | 10 | DAC code register |
| pd_o | output | 1 | Effective power-down (software bit or shutdown) |

## Verification
The assertions assume that the master holds SDA steady while SCL is high, except when it signals a start or stop. They also assume that every intended level on either line lasts well over FILT_CYCLES clocks, so that both filtered lines keep their relative order. The stimulus meets these assumptions with a 30-clock quarter bit: SDA changes only in the middle of SCL-low phases, and the start and stop edges fall in the middle of SCL-high phases. The only shorter pulses are deliberate spikes of 8 clocks, one on SCL while it is low and one on SDA while SCL is high, both of which the filter must remove.

// File: rtl/dac_i2c_pkg.sv
// Shared types and word-layout constants for the DAC control port.
// Assumes a 16-bit control word that carries the power-down flag and the code.
package dac_i2c_pkg;

    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int PD_POS   = 15;  // software power-down bit in the word
    localparam int CODE_LSB = 4;   // word bit that holds code bit 0

    typedef enum logic [2:0] {
        S_IDLE,   // waiting for a start
        S_ADDR,   // shifting the address byte
        S_AACK,   // driving the address acknowledge
        S_WBYTE,  // shifting a write data byte
        S_WACK,   // driving a data acknowledge
        S_RBYTE,  // shifting a read byte out
        S_RACK,   // sampling the master's ack or nack
        S_SKIP    // ignoring the bus until the next start or stop
    } link_state_e;

endpackage

// File: rtl/i2c_pin_filter.sv
// Synchronizes one raw bus pin and removes pulses shorter than FILT_CYCLES.
// Assumes the pin idles high; the output flips only after the synchronized
// input has differed from it on FILT_CYCLES consecutive clocks.
module i2c_pin_filter #(
    parameter int FILT_CYCLES = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CNT_W = $clog2(FILT_CYCLES + 1);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] run_q;
    logic             clean_q;

    // Two-flop synchronizer for the asynchronous pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], raw_i};
    end

    // Count consecutive differing samples and flip once the run is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            clean_q <= 1'b1;
        end else if (sync_q[1] == clean_q) begin
            run_q <= '0;
        end else if (run_q == CNT_W'(FILT_CYCLES - 1)) begin
            run_q   <= '0;
            clean_q <= sync_q[1];
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign clean_o = clean_q;

    // R10
    glitch_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_q != $past(clean_q)) |-> ($past(sync_q[1]) == clean_q));

endmodule

// File: rtl/i2c_bus_cond.sv
// Turns the filtered SCL and SDA levels into single-cycle bus events.
// Assumes both inputs are already synchronized and deglitched.
module i2c_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_p, sda_p;

    // Keep the previous levels of both lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_i;
            sda_p <= sda_i;
        end
    end

    // Decode edges and SDA transitions that happen while SCL stays high.
    always_comb begin
        scl_rise_o = scl_i & ~scl_p;
        scl_fall_o = ~scl_i & scl_p;
        start_o    = scl_i & scl_p & sda_p & ~sda_i;
        stop_o     = scl_i & scl_p & ~sda_p & sda_i;
    end

endmodule

// File: rtl/dac_i2c_link.sv
// Byte-level target engine: address match, write assembly, read return,
// acknowledges, and the held word, code and power-down registers.
// Assumes single-cycle bus events from i2c_bus_cond and a filtered SDA level.
module dac_i2c_link
    import dac_i2c_pkg::*;
#(
    parameter int         CODE_W      = 10,
    parameter logic [6:0] DEV_ADDR    = 7'h0C,
    parameter int         IGNORE_LSBS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic [CODE_W-1:0] dac_code_o,
    output logic              sw_pd_o
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

    link_state_e        state_q;
    logic [3:0]         bit_cnt_q;
    logic               byte_idx_q;
    logic [BYTE_W-1:0]  sh_q, hi_q, tx_q;
    logic               rw_q, ack_q, pull_q;
    logic [WORD_W-1:0]  in_reg_q;
    logic [CODE_W-1:0]  dac_q;
    logic               pd_q;

    logic               addr_hit, wr_commit, rd_clear, quiet;
    logic [WORD_W-1:0]  word_in;

    // Decode the address match and the commit and clear strobes.
    always_comb begin
        quiet     = !start_i && !stop_i;
        addr_hit  = sh_q[BYTE_W-1:1+IGNORE_LSBS] == DEV_ADDR[6:IGNORE_LSBS];
        word_in   = {hi_q, sh_q};
        wr_commit = quiet && state_q == S_WBYTE && scl_fall_i
                    && bit_cnt_q == LAST_BIT && byte_idx_q;
        rd_clear  = quiet && state_q == S_RBYTE && scl_fall_i
                    && bit_cnt_q == 4'd7 && byte_idx_q;
    end

    // Bus protocol state machine and SDA pull-low control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            bit_cnt_q  <= '0;
            byte_idx_q <= 1'b0;
            sh_q       <= '0;
            hi_q       <= '0;
            tx_q       <= '0;
            rw_q       <= 1'b0;
            ack_q      <= 1'b0;
            pull_q     <= 1'b0;
        end else if (stop_i) begin
            state_q <= S_IDLE;
            pull_q  <= 1'b0;
        end else if (start_i) begin
            state_q    <= S_ADDR;
            bit_cnt_q  <= '0;
            byte_idx_q <= 1'b0;
            pull_q     <= 1'b0;
        end else begin
            case (state_q)
                S_ADDR: begin
                    if (scl_rise_i) begin
                        sh_q      <= {sh_q[BYTE_W-2:0], sda_i};
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end else if (scl_fall_i && bit_cnt_q == LAST_BIT) begin
                        if (addr_hit) begin
                            state_q <= S_AACK;
                            pull_q  <= 1'b1;
                            rw_q    <= sh_q[0];
                        end else begin
                            state_q <= S_SKIP;
                        end
                    end
                end
                S_AACK: begin
                    if (scl_fall_i) begin
                        bit_cnt_q <= '0;
                        if (rw_q) begin
                            state_q <= S_RBYTE;
                            tx_q    <= in_reg_q[WORD_W-1 -: BYTE_W];
                            pull_q  <= ~in_reg_q[WORD_W-1];
                        end else begin
                            state_q <= S_WBYTE;
                            pull_q  <= 1'b0;
                        end
                    end
                end
                S_WBYTE: begin
                    if (scl_rise_i) begin
                        sh_q      <= {sh_q[BYTE_W-2:0], sda_i};
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end else if (scl_fall_i && bit_cnt_q == LAST_BIT) begin
                        state_q <= S_WACK;
                        pull_q  <= 1'b1;
                        if (!byte_idx_q) hi_q <= sh_q;
                    end
                end
                S_WACK: begin
                    if (scl_fall_i) begin
                        pull_q    <= 1'b0;
                        bit_cnt_q <= '0;
                        if (byte_idx_q) begin
                            state_q <= S_SKIP;
                        end else begin
                            byte_idx_q <= 1'b1;
                            state_q    <= S_WBYTE;
                        end
                    end
                end
                S_RBYTE: begin
                    if (scl_fall_i) begin
                        if (bit_cnt_q == 4'd7) begin
                            pull_q  <= 1'b0;
                            state_q <= S_RACK;
                        end else begin
                            tx_q      <= {tx_q[BYTE_W-2:0], 1'b0};
                            pull_q    <= ~tx_q[BYTE_W-2];
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise_i) begin
                        ack_q <= ~sda_i;
                    end else if (scl_fall_i) begin
                        if (ack_q && !byte_idx_q) begin
                            byte_idx_q <= 1'b1;
                            bit_cnt_q  <= '0;
                            tx_q       <= in_reg_q[BYTE_W-1:0];
                            pull_q     <= ~in_reg_q[BYTE_W-1];
                            state_q    <= S_RBYTE;
                        end else begin
                            state_q <= S_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Held word, DAC code and software power-down registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_reg_q <= '0;
            dac_q    <= '0;
            pd_q     <= 1'b0;
        end else if (wr_commit) begin
            in_reg_q <= word_in;
            dac_q    <= word_in[CODE_LSB +: CODE_W];
            pd_q     <= word_in[PD_POS];
        end else if (rd_clear) begin
            in_reg_q <= '0;
        end
    end

    assign sda_pull_o = pull_q;
    assign dac_code_o = dac_q;
    assign sw_pd_o    = pd_q;

    // R1
    start_enters_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_q == S_ADDR));

    // R2
    ack_only_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_AACK && $rose(pull_q)) |-> addr_hit);

    // R4
    code_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_commit |=> ($stable(dac_q) && $stable(pd_q)));

    // R7
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clear |=> (in_reg_q == '0 && $stable(dac_q)));

    // R12
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE || state_q == S_SKIP) |-> !pull_q);

endmodule

// File: rtl/dac_i2c_ctrl.sv
// Top of the DAC control port: pin filters, bus condition decode, the target
// engine, and the asynchronous shutdown merge onto the power-down output.
// Assumes clk runs at least FILT_CYCLES*4 times faster than SCL.
module dac_i2c_ctrl #(
    parameter int         FILT_CYCLES = 13,
    parameter int         CODE_W      = 10,
    parameter logic [6:0] DEV_ADDR    = 7'h0C,
    parameter int         IGNORE_LSBS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              shdn_n_i,
    output logic              sda_pull_o,
    output logic [CODE_W-1:0] dac_code_o,
    output logic              pd_o
);
    localparam int N_PINS = 2;

    logic [N_PINS-1:0] raw_pins, clean_pins;
    logic scl_rise, scl_fall, start_ev, stop_ev, sw_pd;

    assign raw_pins = {sda_i, scl_i};

    // One filter per bus pin.
    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        i2c_pin_filter #(.FILT_CYCLES(FILT_CYCLES)) i_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (raw_pins[p]),
            .clean_o (clean_pins[p])
        );
    end

    i2c_bus_cond i_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (clean_pins[0]),
        .sda_i      (clean_pins[1]),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    dac_i2c_link #(
        .CODE_W      (CODE_W),
        .DEV_ADDR    (DEV_ADDR),
        .IGNORE_LSBS (IGNORE_LSBS)
    ) i_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_ev),
        .stop_i     (stop_ev),
        .sda_i      (clean_pins[1]),
        .sda_pull_o (sda_pull_o),
        .dac_code_o (dac_code_o),
        .sw_pd_o    (sw_pd)
    );

    // The shutdown pin bypasses the clock so it acts immediately.
    assign pd_o = sw_pd | ~shdn_n_i;

endmodule

// File: tb/test_dac_i2c_ctrl.sv
module test_dac_i2c_ctrl;
    localparam int Q = 30;

    logic clk = 1'b0, rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1, shdn_n = 1'b1;
    logic sda_pull, pd;
    logic [9:0] code;
    logic sda_line;
    assign sda_line = m_sda & ~sda_pull;

    always #2 clk = ~clk;

    dac_i2c_ctrl i_dac_i2c_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .shdn_n_i(shdn_n), .sda_pull_o(sda_pull), .dac_code_o(code), .pd_o(pd)
    );

    int checks = 0, errs = 0;
    bit cmp_en = 1'b0;
    logic [15:0] exp_reg = '0;
    logic [9:0]  exp_code = '0;
    bit          exp_pd = 1'b0;
    logic [7:0]  rd_q[$];

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model compared on every clock: R4 R5 R9
    always @(negedge clk) begin
        if (cmp_en) begin
            checks++;
            if (code !== exp_code || pd !== (exp_pd | ~shdn_n)) begin
                errs++;
                $display("FAIL R4/R5 per-clock: code=%0h pd=%0b expected code=%0h pd=%0b",
                         code, pd, exp_code, exp_pd | ~shdn_n);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_cyc(Q);
        m_scl = 1'b1; wait_cyc(Q);
        m_sda = 1'b0; wait_cyc(Q);
        m_scl = 1'b0; wait_cyc(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_cyc(Q);
        m_scl = 1'b1; wait_cyc(Q);
        m_sda = 1'b1; wait_cyc(2*Q);
    endtask

    task automatic send_bit(input bit b, input bit g_scl, input bit g_sda);
        m_sda = b;
        if (g_scl) begin
            wait_cyc(5); m_scl = 1'b1; wait_cyc(8); m_scl = 1'b0; wait_cyc(Q-13);
        end else wait_cyc(Q);
        m_scl = 1'b1;
        if (g_sda) begin
            wait_cyc(10); m_sda = ~b; wait_cyc(8); m_sda = b; wait_cyc(2*Q-18);
        end else wait_cyc(2*Q);
        m_scl = 1'b0; wait_cyc(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, input bit g, output bit acked);
        for (int i = 7; i >= 0; i--) send_bit(v[i], g && i == 4, g && i == 2);
        m_sda = 1'b1; wait_cyc(Q);
        m_scl = 1'b1; wait_cyc(Q);
        acked = !sda_line; wait_cyc(Q);
        m_scl = 1'b0; wait_cyc(Q);
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit give_ack);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_cyc(Q); m_scl = 1'b1; wait_cyc(Q);
            v[i] = sda_line; wait_cyc(Q);
            m_scl = 1'b0; wait_cyc(Q);
        end
        m_sda = give_ack ? 1'b0 : 1'b1; wait_cyc(Q);
        m_scl = 1'b1; wait_cyc(2*Q);
        m_scl = 1'b0; wait_cyc(Q);
    endtask

    task automatic wr_body(input logic [6:0] a, input logic [15:0] w, input bit g, input string tag);
        bit hit, k;
        hit = (a[6:2] == 5'b00011);
        send_byte({a, 1'b0}, 1'b0, k); chk({tag, " address ack"}, k, hit);
        send_byte(w[15:8], g, k);      chk({tag, " high byte ack"}, k, hit);
        if (hit) cmp_en = 1'b0;
        send_byte(w[7:0], 1'b0, k);    chk({tag, " low byte ack"}, k, hit);
        if (hit) begin
            exp_reg = w; exp_code = w[13:4]; exp_pd = w[15];
        end
        cmp_en = 1'b1;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [15:0] w, input bit g, input string tag);
        bus_start();
        wr_body(a, w, g, tag);
        bus_stop();
        chk("R12 SDA released after stop", sda_pull, 0);
    endtask

    task automatic do_read(input logic [6:0] a, input string tag);
        bit k;
        logic [7:0] v;
        rd_q.push_back(exp_reg[15:8]);
        rd_q.push_back(exp_reg[7:0]);
        bus_start();
        send_byte({a, 1'b1}, 1'b0, k); chk({tag, " R2 read address ack"}, k, 1);
        recv_byte(v, 1'b1); chk({tag, " high byte"}, v, rd_q.pop_front());
        recv_byte(v, 1'b0); chk({tag, " low byte"}, v, rd_q.pop_front());
        exp_reg = '0;
        chk("R11 released after NACK", sda_pull, 0);
        bus_stop();
    endtask

    initial begin : main
        bit k;
        logic [7:0] v;
        wait_cyc(10);
        rst_n = 1'b1;
        wait_cyc(5);
        chk("R8 reset code", code, 0);
        chk("R8 reset pd", pd, 0);
        chk("R8 reset SDA pull", sda_pull, 0);
        cmp_en = 1'b1;

        // R3 R5: full write at base address
        do_write(7'h0C, 16'h3FF0, 1'b0, "R3");
        chk("R5 code after write", code, 10'h3FF);

        // R2 R5: top alias address, unused bits set, power-down set
        do_write(7'h0F, 16'hD55F, 1'b0, "R2");
        chk("R5 code ignores bits 14 and 3:0", code, 10'h155);
        chk("R5 software power-down", pd, 1);

        // R2: non-matching address, no ack, nothing changes
        do_write(7'h1C, 16'h1230, 1'b0, "R2 mismatch");

        // R4: stop after one data byte commits nothing
        bus_start();
        send_byte({7'h0D, 1'b0}, 1'b0, k); chk("R4 partial address ack", k, 1);
        send_byte(8'hAB, 1'b0, k);         chk("R4 partial byte ack", k, 1);
        bus_stop();
        chk("R4 code after partial write", code, 10'h155);

        // R6: read returns held word; R7: then it is cleared
        do_read(7'h0E, "R6 read");
        do_read(7'h0C, "R7 read after clear");
        chk("R7 code unchanged by read", code, 10'h155);

        // R3: a third data byte is not acknowledged
        bus_start();
        wr_body(7'h0C, 16'h2A50, 1'b0, "R3");
        send_byte(8'hFF, 1'b0, k); chk("R3 third byte nack", k, 0);
        bus_stop();
        chk("R3 code after write", code, 10'h2A5);

        // R1 R11: repeated start from write to read, NACK after first byte
        bus_start();
        send_byte({7'h0C, 1'b0}, 1'b0, k); chk("R1 write address ack", k, 1);
        bus_start();
        send_byte({7'h0C, 1'b1}, 1'b0, k); chk("R1 read address after repeated start", k, 1);
        recv_byte(v, 1'b0); chk("R1 byte after repeated start", v, 8'h2A);
        wait_cyc(2*Q);
        chk("R11 SDA released after NACK", sda_pull, 0);
        bus_stop();
        do_read(7'h0C, "R11 word kept after short read");

        // R1: two writes joined by a repeated start
        bus_start();
        wr_body(7'h0C, 16'h8000, 1'b0, "R1 first");
        bus_start();
        wr_body(7'h0C, 16'h1230, 1'b0, "R1 second");
        bus_stop();
        chk("R1 code after chained writes", code, 10'h123);

        // R10: short spikes on SCL and SDA are ignored
        do_write(7'h0C, 16'h0F84, 1'b1, "R10");
        chk("R10 code after glitched write", code, 10'h0F8);

        // R9: shutdown pin forces power-down immediately
        @(negedge clk); #1 shdn_n = 1'b0;
        #1 chk("R9 pd forced by shutdown", pd, 1);
        do_write(7'h0C, 16'h3000, 1'b0, "R9 write in shutdown");
        chk("R9 pd still forced", pd, 1);
        @(negedge clk); #1 shdn_n = 1'b1;
        #1 chk("R9 pd released", pd, 0);
        wait_cyc(20);

        cmp_en = 1'b0;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog (all requirements): run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule